// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block is one divider channel that runs on a fast input clock and makes a slower output clock. The time the output spends low and the time it spends high are set separately, each as a number of input clock cycles. A chip-wide synchronous SYNC pulse realigns every channel that obeys it. While SYNC is held, the output rests at a chosen start level. After SYNC is released, each channel waits its own offset in input cycles and then begins its first phase, so channels that share one SYNC come out with known relative timing.

Each channel can also be set to ignore SYNC. When SYNC is ignored, the output can be pinned to a static level. A bypass select passes the input clock straight to the output. All settings are static input pins. The block has no data stream, so it has no valid/ready handshake: every pin is a plain control or status level.

Top module: `duty_div_channel`

## Requirements
- R1: With a low-count field value L, each low phase of the output lasts exactly L+1 input cycles. A value of 0 gives a one-cycle phase.
- R2: With a high-count field value H, each high phase lasts exactly H+1 input cycles. A value of 0 gives a one-cycle phase.
- R3: When the force flag and the ignore-SYNC flag are both 1, the output is held at the force value. When the ignore-SYNC flag is 0, the force flag has no effect on the output.
- R4: When the ignore-SYNC flag is 1, a SYNC pulse does not change the lengths or the levels of the running phases.
- R5: While SYNC is high and obeyed, the output holds the start level (1 when start-high is set, otherwise 0), beginning one clock edge after SYNC is first sampled. After release, the first phase has the start level.
- R6: After an obeyed SYNC is released, the first phase is longer by the phase-offset value, in input cycles. Two channels released by the same SYNC have first transitions that differ by the difference of their offsets.
- R7: A change to the low or high count field takes effect only at the next phase boundary. A phase that is already running keeps the length it had when it started.
- R8: When bypass is 1, the output equals the input clock. Bypass takes priority over the force setting and over the divider.
- R9: While reset is asserted, with bypass and force both off, the output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Chip-wide synchronous SYNC, active high |
| low_cnt_i | input | CNT_W | Low phase length minus one |
| high_cnt_i | input | CNT_W | High phase length minus one |
| bypass_i | input | 1 | 1: output follows the input clock |
| ignore_sync_i | input | 1 | 1: this channel ignores SYNC |
| force_en_i | input | 1 | 1: pin the output to a static level (needs ignore_sync_i) |
| force_lvl_i | input | 1 | Level used when forcing |
| start_high_i | input | 1 | Level of the first phase after SYNC |
| phase_ofs_i | input | OFS_W | Extra input cycles before the first phase |
| div_o | output | 1 | Divided clock output |

## Verification
The hardest case to reach from the ports is a count change that lands in the middle of a running phase. It has to be shown that the running phase keeps its old length and that the next phase uses the new one. To reach it, the bench synchronizes with long phases, changes both fields a few cycles into the first phase, and lets the scoreboard expect the old length first and the new length after it. The offset case is reached by placing two channels on one SYNC with different offsets and timing each channel's first transition from the release.

// File: rtl/duty_div_pkg.sv
package duty_div_pkg;
  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } level_e;
endpackage

// File: rtl/dd_sync_gate.sv
module dd_sync_gate #(
  parameter int OFS_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             sync_i,
  input  logic             ignore_i,
  input  logic [OFS_W-1:0] offset_i,
  output logic             restart_o,
  output logic             step_o
);
  logic [OFS_W-1:0] dly_q;

  assign restart_o = sync_i & ~ignore_i;
  assign step_o    = ~restart_o & (dly_q == '0);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      dly_q <= '0;
    end else if (restart_o) begin
      dly_q <= offset_i;
    end else if (dly_q != '0) begin
      dly_q <= dly_q - 1'b1;
    end
  end

  // offset delay is armed by every obeyed SYNC
  assert_restart_loads_offset_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    restart_o |=> dly_q == $past(offset_i));

  // an ignored SYNC never opens a delay window
  assert_ignored_sync_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (ignore_i && dly_q == '0) |=> dly_q == '0);
endmodule

// File: rtl/dd_phase_ctr.sv
module dd_phase_ctr
  import duty_div_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             restart_i,
  input  logic             step_i,
  input  logic             start_high_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  input  logic [CNT_W-1:0] high_cnt_i,
  output logic             lvl_o
);
  level_e           lvl_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      lvl_q <= LVL_LOW;
      cnt_q <= '0;
      lim_q <= '0;
    end else if (restart_i) begin
      lvl_q <= start_high_i ? LVL_HIGH : LVL_LOW;
      cnt_q <= '0;
      lim_q <= start_high_i ? high_cnt_i : low_cnt_i;
    end else if (step_i) begin
      if (cnt_q == lim_q) begin
        lvl_q <= (lvl_q == LVL_HIGH) ? LVL_LOW : LVL_HIGH;
        cnt_q <= '0;
        lim_q <= (lvl_q == LVL_HIGH) ? low_cnt_i : high_cnt_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lvl_o = (lvl_q == LVL_HIGH);

  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cnt_q <= lim_q);

  assert_boundary_toggles_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (step_i && cnt_q == lim_q) |=> lvl_q != $past(lvl_q));

  assert_mid_phase_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!restart_i && cnt_q != lim_q) |=> $stable(lvl_q));

  assert_restart_start_lvl_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    restart_i |=> lvl_o == $past(start_high_i));

  assert_delay_freezes_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!restart_i && !step_i) |=> ($stable(lvl_q) && $stable(cnt_q)));
endmodule

// File: rtl/dd_out_sel.sv
module dd_out_sel (
  input  logic clk_i,
  input  logic bypass_i,
  input  logic ignore_i,
  input  logic force_en_i,
  input  logic force_lvl_i,
  input  logic div_lvl_i,
  output logic out_o
);
  logic force_act;

  assign force_act = force_en_i & ignore_i;

  always_comb begin
    if (bypass_i)       out_o = clk_i;
    else if (force_act) out_o = force_lvl_i;
    else                out_o = div_lvl_i;
  end
endmodule

// File: rtl/duty_div_channel.sv
module duty_div_channel #(
  parameter int CNT_W = 4,
  parameter int OFS_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  input  logic [CNT_W-1:0] high_cnt_i,
  input  logic             bypass_i,
  input  logic             ignore_sync_i,
  input  logic             force_en_i,
  input  logic             force_lvl_i,
  input  logic             start_high_i,
  input  logic [OFS_W-1:0] phase_ofs_i,
  output logic             div_o
);
  logic restart;
  logic step;
  logic div_lvl;

  dd_sync_gate #(.OFS_W(OFS_W)) u_gate (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .sync_i    (sync_i),
    .ignore_i  (ignore_sync_i),
    .offset_i  (phase_ofs_i),
    .restart_o (restart),
    .step_o    (step)
  );

  dd_phase_ctr #(.CNT_W(CNT_W)) u_phase (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .restart_i    (restart),
    .step_i       (step),
    .start_high_i (start_high_i),
    .low_cnt_i    (low_cnt_i),
    .high_cnt_i   (high_cnt_i),
    .lvl_o        (div_lvl)
  );

  dd_out_sel u_out (
    .clk_i       (clk_i),
    .bypass_i    (bypass_i),
    .ignore_i    (ignore_sync_i),
    .force_en_i  (force_en_i),
    .force_lvl_i (force_lvl_i),
    .div_lvl_i   (div_lvl),
    .out_o       (div_o)
  );

  // an obeyed SYNC cannot coexist with a phase step in the same cycle
  assert_sync_blocks_step_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (sync_i && !ignore_sync_i) |-> !step);
endmodule

// File: tb/duty_div_channel_tb.sv
module duty_div_channel_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       sync = 1'b0;
  logic [3:0] low_c = '0, high_c = '0, ofs_a = '0, ofs_b = '0;
  logic       byp = 1'b0, ign = 1'b0, fen = 1'b0, flvl = 1'b0, sth = 1'b0;
  logic       div_a, div_b;

  duty_div_channel u_dut (
    .clk_i(clk), .rst_n_i(rst_n), .sync_i(sync), .low_cnt_i(low_c), .high_cnt_i(high_c),
    .bypass_i(byp), .ignore_sync_i(ign), .force_en_i(fen), .force_lvl_i(flvl),
    .start_high_i(sth), .phase_ofs_i(ofs_a), .div_o(div_a));

  duty_div_channel u_dut_b (
    .clk_i(clk), .rst_n_i(rst_n), .sync_i(sync), .low_cnt_i(low_c), .high_cnt_i(high_c),
    .bypass_i(1'b0), .ignore_sync_i(ign), .force_en_i(fen), .force_lvl_i(flvl),
    .start_high_i(sth), .phase_ofs_i(ofs_b), .div_o(div_b));

  typedef struct {
    logic  lvl;
    int    len;
    string req;
  } item_t;

  item_t exq[$];
  int    checks = 0, errors = 0;
  bit    mon_en = 1'b0;
  bit    done = 1'b0;
  int    run_len = 0;
  logic  run_lvl = 1'b0;
  event  boundary;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: measures run lengths of div_a and scores them against the queue
  always @(negedge clk) begin
    if (!rst_n || !mon_en || (sync && !ign)) begin
      run_len = 0;
      run_lvl = div_a;
    end else if (div_a === run_lvl) begin
      run_len++;
    end else begin
      if (exq.size() > 0) begin
        item_t e;
        e = exq.pop_front();
        chk(run_lvl === e.lvl, e.req, "phase level", int'(run_lvl), int'(e.lvl));
        chk(run_len == e.len, e.req, "phase length", run_len, e.len);
      end
      run_lvl = div_a;
      run_len = 1;
      ->boundary;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(logic lvl, int len, string req);
    item_t e;
    e.lvl = lvl; e.len = len; e.req = req;
    exq.push_back(e);
  endtask

  task automatic do_sync();
    tick();
    sync = 1'b1;
    tick();
    tick();
    sync = 1'b0;
  endtask

  task automatic drain(string req);
    int t = 0;
    while (exq.size() > 0 && t < 300) begin
      @(negedge clk);
      t++;
    end
    chk(exq.size() == 0, req, "pending items", exq.size(), 0);
    exq.delete();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    chk(div_a === 1'b0, "R9", "output in reset", int'(div_a), 0);
    tick();
    rst_n = 1'b1;
    tick();

    // R1/R2: asymmetric phases, start low
    mon_en = 1'b1;
    low_c = 4'd3; high_c = 4'd5; sth = 1'b0; ofs_a = 4'd0;
    do_sync();
    push(1'b0, 4, "R1"); push(1'b1, 6, "R2"); push(1'b0, 4, "R1"); push(1'b1, 6, "R2");
    drain("R1");

    // R5 + R2 boundary: start high, field 0 gives one cycle
    low_c = 4'd1; high_c = 4'd0; sth = 1'b1;
    do_sync();
    push(1'b1, 1, "R5"); push(1'b0, 2, "R1"); push(1'b1, 1, "R2"); push(1'b0, 2, "R1");
    drain("R5");

    // R6: offset lengthens first phase
    low_c = 4'd2; high_c = 4'd2; sth = 1'b0; ofs_a = 4'd5;
    do_sync();
    push(1'b0, 8, "R6"); push(1'b1, 3, "R6"); push(1'b0, 3, "R6");
    drain("R6");

    // R6/R1 extremes: max offset and max counts
    low_c = 4'd15; high_c = 4'd15; ofs_a = 4'd15;
    do_sync();
    push(1'b0, 31, "R6"); push(1'b1, 16, "R2"); push(1'b0, 16, "R1");
    drain("R6");

    // R7: field change in mid phase
    low_c = 4'd7; high_c = 4'd7; ofs_a = 4'd0;
    do_sync();
    push(1'b0, 8, "R7"); push(1'b1, 2, "R7"); push(1'b0, 2, "R7");
    repeat (3) @(negedge clk);
    low_c = 4'd1; high_c = 4'd1;
    drain("R7");

    // R4: ignored SYNC leaves running phases intact
    ign = 1'b1; low_c = 4'd2; high_c = 4'd2;
    repeat (12) tick();
    @(boundary);
    push(div_a, 3, "R4"); push(~div_a, 3, "R4"); push(div_a, 3, "R4");
    tick();
    sync = 1'b1;
    tick();
    sync = 1'b0;
    drain("R4");

    // R3: force under ignore
    mon_en = 1'b0;
    fen = 1'b1; flvl = 1'b1;
    tick();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(div_a === 1'b1, "R3", "forced high", int'(div_a), 1);
    end
    flvl = 1'b0;
    tick();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(div_a === 1'b0, "R3", "forced low", int'(div_a), 0);
    end
    // R3: force without ignore has no effect
    ign = 1'b0; flvl = 1'b1; mon_en = 1'b1;
    do_sync();
    push(1'b0, 3, "R3"); push(1'b1, 3, "R3"); push(1'b0, 3, "R3");
    drain("R3");
    fen = 1'b0; flvl = 1'b0;

    // R5: hold at start level while SYNC held
    mon_en = 1'b0;
    sth = 1'b1; low_c = 4'd0; high_c = 4'd0;
    tick();
    sync = 1'b1;
    tick();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(div_a === 1'b1, "R5", "held start level", int'(div_a), 1);
    end
    tick();
    sync = 1'b0;
    tick();

    // R6: two channels, same SYNC, different offsets
    begin
      int ta = 0, tb = 0;
      sth = 1'b0; low_c = 4'd3; high_c = 4'd3; ofs_a = 4'd2; ofs_b = 4'd9;
      do_sync();
      for (int k = 1; k <= 40; k++) begin
        @(negedge clk);
        if (ta == 0 && div_a !== 1'b0) ta = k;
        if (tb == 0 && div_b !== 1'b0) tb = k;
      end
      chk(ta == 7, "R6", "channel A first edge", ta, 7);
      chk(tb == 14, "R6", "channel B first edge", tb, 14);
      chk(tb - ta == 7, "R6", "channel skew", tb - ta, 7);
    end

    // R8: bypass follows the input clock, even with force set
    byp = 1'b1; ign = 1'b1; fen = 1'b1; flvl = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      chk(div_a === 1'b1, "R8", "bypass clock high", int'(div_a), 1);
      @(negedge clk); #1;
      chk(div_a === 1'b0, "R8", "bypass clock low", int'(div_a), 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule